// File: doc/BRIEF.md
# Input Attenuator Range Selector

This block picks the attenuation level of a switchable input voltage divider that sits in front of a low-voltage sensing stage. Two comparator flags watch the divided output: `hi_flag` says it is above an upper threshold, and `lo_flag` says it is below a lower threshold. The block holds a level index over `NUM_LEVELS` settings. Level 0 gives the heaviest division. Level `NUM_LEVELS-1` is the direct, undivided path. The flags alone move the index up or down one step at a time. No external command is involved.

Each step passes through a one-cycle transition state. During that cycle a divider-reset pulse is issued so the divider capacitors can be reinitialized. A settling window then follows, and the flags are ignored while it runs. If the output is still too high at the heaviest division, the block enters an overload state. In that state it requests an unconditional inversion of the sensed voltage. It stays there until the high flag has been quiet for a full settling window, and then returns to tracking at level 0.

The flags are assumed to be synchronous to `clk`. `settle_cycles` sets the window length in clock cycles, and a value of 0 behaves as 1.

Top module: `div_range_sel`

## Requirements
- R1: While reset is held, and after it is released until a flag acts, `lvl_idx` is 0, `lvl_sel_oh` is 1, and both `div_rst` and `flip_req` are 0.
- R2: When tracking at level L>0 with `hi_flag`=1, the next cycle is a step-down cycle with `div_rst`=1 and `lvl_idx` still L. The cycle after that shows `lvl_idx`=L-1.
- R3: When tracking at level L<NUM_LEVELS-1 with `lo_flag`=1 and `hi_flag`=0, the next cycle is a step-up cycle with `div_rst`=1. The cycle after that shows `lvl_idx`=L+1.
- R4: If `hi_flag` and `lo_flag` are both 1 while tracking, the block acts on `hi_flag` only.
- R5: At level NUM_LEVELS-1, `lo_flag` alone has no effect: the level stays the same and `div_rst` stays 0. `lvl_idx` never exceeds NUM_LEVELS-1.
- R6: If `hi_flag`=1 while tracking at level 0, the block enters overload from the next cycle. In overload, `flip_req`=1 every cycle, `lvl_idx` stays 0, and `div_rst` stays 0.
- R7: Overload ends after max(K,1) consecutive cycles with `hi_flag`=0, where K is `settle_cycles`. Any `hi_flag`=1 in overload restarts that count. Afterwards the block tracks again at level 0.
- R8: After a step cycle, the flags are ignored for max(K,1) cycles, where K is `settle_cycles` sampled during the step cycle.
- R9: `lvl_sel_oh` has exactly one bit set, and that bit is bit `lvl_idx`.
- R10: `div_rst` is never high for two cycles in a row and is high only in step cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hi_flag | input | 1 | Divided output above the upper threshold |
| lo_flag | input | 1 | Divided output below the lower threshold |
| settle_cycles | input | CNT_W | Settling window length in cycles (0 acts as 1) |
| lvl_idx | output | IDX_W | Binary index of the selected division level |
| lvl_sel_oh | output | NUM_LEVELS | One-hot level select |
| div_rst | output | 1 | Divider-reset pulse during a level step |
| flip_req | output | 1 | Overload inversion request |

## Verification
The first stimulus is directed walks. They step the level from 0 to the top and back, so an off-by-one in either step direction separates from the correct one. Further directed cases cover `lo_flag` held at the top level and both flags raised together. They also include `hi_flag` held and then pulsed inside overload, which exposes a wrong priority, a missing top clamp, or an exit count that fails to restart. After that, biased random flags are applied under varying settling lengths, including 0 and 1. These runs mix flag activity inside settling windows, where it must be ignored, with activity in the tracking state, where it must act. A reference model advanced each cycle is compared against every output.

// File: rtl/div_range_sel_pkg.sv
package div_range_sel_pkg;

  typedef enum logic [2:0] {
    RS_TRACK  = 3'd0,
    RS_DOWN   = 3'd1,
    RS_UP     = 3'd2,
    RS_SETTLE = 3'd3,
    RS_OVER   = 3'd4
  } rs_state_e;

endpackage

// File: rtl/rs_blank_timer.sv
module rs_blank_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] reload_val,
  output logic             expiring
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? reload_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expiring = (cnt_q <= CNT_W'(1));

  // R8
  timer_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(reload_val)));

endmodule

// File: rtl/rs_level_reg.sv
module rs_level_reg #(
  parameter int NUM_LEVELS = 4,
  parameter int IDX_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_up,
  input  logic                  step_dn,
  output logic [IDX_W-1:0]      idx,
  output logic [NUM_LEVELS-1:0] sel_oh,
  output logic                  at_min,
  output logic                  at_max
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_LEVELS - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = (step_up & (idx_q != TOP_IDX)) | (step_dn & (idx_q != '0));
    idx_d  = step_dn ? (idx_q - IDX_W'(1)) : (idx_q + IDX_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_dec
    assign sel_oh[g] = (idx_q == IDX_W'(g));
  end

  assign idx    = idx_q;
  assign at_min = (idx_q == '0);
  assign at_max = (idx_q == TOP_IDX);

  // R5
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= TOP_IDX);

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sel_oh) && sel_oh[idx_q]);

  // R2
  step_dn_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !at_min) |=> (idx_q == $past(idx_q) - IDX_W'(1)));

  // R3
  step_up_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !at_max) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import div_range_sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hi_flag,
  input  logic lo_flag,
  input  logic at_min,
  input  logic at_max,
  input  logic tmr_expiring,
  output logic tmr_load,
  output logic tmr_run,
  output logic step_up,
  output logic step_dn,
  output logic div_rst,
  output logic flip_req
);

  rs_state_e st_q;
  rs_state_e st_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_run  = 1'b0;
    unique case (st_q)
      RS_TRACK: begin
        if (hi_flag) begin
          if (at_min) begin
            st_d     = RS_OVER;
            tmr_load = 1'b1;
          end else begin
            st_d = RS_DOWN;
          end
        end else if (lo_flag && !at_max) begin
          st_d = RS_UP;
        end
      end
      RS_DOWN, RS_UP: begin
        tmr_load = 1'b1;
        st_d     = RS_SETTLE;
      end
      RS_SETTLE: begin
        tmr_run = 1'b1;
        if (tmr_expiring) st_d = RS_TRACK;
      end
      RS_OVER: begin
        if (hi_flag) begin
          tmr_load = 1'b1;
        end else begin
          tmr_run = 1'b1;
          if (tmr_expiring) st_d = RS_TRACK;
        end
      end
      default: st_d = RS_TRACK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RS_TRACK;
    end else begin
      st_q <= st_d;
    end
  end

  assign step_dn  = (st_q == RS_DOWN);
  assign step_up  = (st_q == RS_UP);
  assign div_rst  = step_dn | step_up;
  assign flip_req = (st_q == RS_OVER);

  // R10
  div_rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst |=> !div_rst);

  // R6
  over_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_TRACK && hi_flag && at_min) |=> flip_req);

  // R6
  over_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip_req |-> (at_min && !div_rst));

  // R4
  hi_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_TRACK && hi_flag && lo_flag) |=> !step_up);

  // R7
  over_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_req && hi_flag) |=> flip_req);

endmodule

// File: rtl/div_range_sel.sv
module div_range_sel #(
  parameter int NUM_LEVELS = 4,
  parameter int CNT_W      = 8,
  localparam int IDX_W     = (NUM_LEVELS > 2) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hi_flag,
  input  logic                  lo_flag,
  input  logic [CNT_W-1:0]      settle_cycles,
  output logic [IDX_W-1:0]      lvl_idx,
  output logic [NUM_LEVELS-1:0] lvl_sel_oh,
  output logic                  div_rst,
  output logic                  flip_req
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic at_min, at_max;
  logic tmr_load, tmr_run, tmr_expiring;
  logic step_up, step_dn;

  rs_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .hi_flag      (hi_flag),
    .lo_flag      (lo_flag),
    .at_min       (at_min),
    .at_max       (at_max),
    .tmr_expiring (tmr_expiring),
    .tmr_load     (tmr_load),
    .tmr_run      (tmr_run),
    .step_up      (step_up),
    .step_dn      (step_dn),
    .div_rst      (div_rst),
    .flip_req     (flip_req)
  );

  rs_blank_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (tmr_load),
    .run        (tmr_run),
    .reload_val (settle_cycles),
    .expiring   (tmr_expiring)
  );

  rs_level_reg #(.NUM_LEVELS(NUM_LEVELS), .IDX_W(IDX_W)) u_level (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .step_up (step_up),
    .step_dn (step_dn),
    .idx     (lvl_idx),
    .sel_oh  (lvl_sel_oh),
    .at_min  (at_min),
    .at_max  (at_max)
  );

  // R5
  top_lo_ignored_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (at_max && lo_flag && !hi_flag && !div_rst) |=> !step_up);

endmodule

// File: tb/tb_div_range_sel.sv
module tb_div_range_sel;

  localparam int N     = 4;
  localparam int CNT_W = 8;
  localparam int IDX_W = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             hi_flag, lo_flag;
  logic [CNT_W-1:0] settle_cycles;
  logic [IDX_W-1:0] lvl_idx;
  logic [N-1:0]     lvl_sel_oh;
  logic             div_rst, flip_req;

  always #2.5 clk = ~clk;

  div_range_sel #(.NUM_LEVELS(N), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .hi_flag(hi_flag), .lo_flag(lo_flag),
    .settle_cycles(settle_cycles), .lvl_idx(lvl_idx), .lvl_sel_oh(lvl_sel_oh),
    .div_rst(div_rst), .flip_req(flip_req)
  );

  int checks = 0;
  int fails  = 0;

  // model: 0 track, 1 down, 2 up, 3 settle, 4 over
  int    m_st  = 0;
  int    m_lvl = 0;
  int    m_cnt = 0;
  string m_tag = "R1";

  function automatic logic [N-1:0] exp_oh(input int lvl);
    logic [N-1:0] v = '0;
    v[lvl] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(m_tag, int'(lvl_idx), m_lvl);
    chk("R9", int'(lvl_sel_oh), int'(exp_oh(m_lvl)));
    chk("R10", int'(div_rst), (m_st == 1 || m_st == 2) ? 1 : 0);
    chk((m_st == 4) ? "R6" : "R7", int'(flip_req), (m_st == 4) ? 1 : 0);
  endtask

  task automatic model_step(input logic h, input logic l, input int k);
    logic expiring;
    expiring = (m_cnt <= 1);
    case (m_st)
      0: begin
        if (h) begin
          m_tag = l ? "R4" : "R2";
          if (m_lvl == 0) begin m_st = 4; m_cnt = k; m_tag = "R6"; end
          else m_st = 1;
        end else if (l) begin
          if (m_lvl != N - 1) begin m_st = 2; m_tag = "R3"; end
          else m_tag = "R5";
        end
      end
      1: begin m_lvl--; m_st = 3; m_cnt = k; m_tag = "R2"; end
      2: begin m_lvl++; m_st = 3; m_cnt = k; m_tag = "R3"; end
      3: begin
        m_tag = "R8";
        if (expiring) m_st = 0;
        else if (m_cnt != 0) m_cnt--;
      end
      4: begin
        m_tag = "R7";
        if (h) m_cnt = k;
        else begin
          if (expiring) m_st = 0;
          else if (m_cnt != 0) m_cnt--;
        end
      end
      default: m_st = 0;
    endcase
  endtask

  task automatic cyc(input logic h, input logic l, input int k);
    @(negedge clk);
    compare_all();
    hi_flag = h;
    lo_flag = l;
    settle_cycles = CNT_W'(k);
    @(posedge clk);
    #0.5;
    model_step(h, l, k);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    hi_flag = 1'b0;
    lo_flag = 1'b0;
    settle_cycles = CNT_W'(2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk("R1", int'(lvl_idx), 0);
    chk("R1", int'(lvl_sel_oh), 1);
    chk("R1", int'(div_rst), 0);
    chk("R1", int'(flip_req), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    m_tag = "R1";
    cyc(0, 0, 2);
    // R3 walk up to top, R5 lo at top
    repeat (20) cyc(0, 1, 2);
    // R4 both flags: step down
    cyc(1, 1, 3);
    repeat (6) cyc(1, 1, 3);
    // R2 walk down to 0 with settle 1 and 0
    repeat (10) cyc(1, 0, 0);
    // R6 overload, hold hi
    repeat (6) cyc(1, 0, 4);
    // R7 pulses of hi restart count
    repeat (3) cyc(0, 0, 4);
    cyc(1, 0, 4);
    repeat (6) cyc(0, 0, 4);
    // R8 flags during settle
    cyc(0, 1, 5);
    repeat (8) cyc(1, 1, 5);
    repeat (4) cyc(0, 0, 5);
    // random phase
    begin
      int seed_dummy;
      seed_dummy = $urandom(1234);
    end
    for (int seg = 0; seg < 60; seg++) begin
      int hp = $urandom_range(5, 60);
      int lp = $urandom_range(5, 60);
      int k  = $urandom_range(0, 4);
      for (int i = 0; i < 60; i++) begin
        logic h = ($urandom_range(0, 99) < hp);
        logic l = ($urandom_range(0, 99) < lp);
        cyc(h, l, k);
      end
    end
    repeat (10) cyc(0, 0, 1);
    summary();
  end

endmodule